// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles, producing a quotient and a remainder of the same width as the operands. A caller presents both operands with a one-cycle `start` pulse while the block is idle. The block then raises `busy` and runs one add-or-subtract iteration per cycle. The sign of the partial remainder picks the operation for the next iteration, so a failed subtraction is never undone inside the loop. After the last iteration, one extra cycle adds the divisor back to the partial remainder if that remainder is negative.

The result appears with a single-cycle `done` pulse. It stays on the output ports until the next accepted division writes a new result. A zero divisor skips the iteration loop: the block raises an error flag, returns an all-ones quotient, and returns the dividend as the remainder.

Top module: `seq_nr_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are all zeros.
- R2: A `start` sampled high while `busy` is low and `done` is low is accepted. The operands are captured on that edge, and `busy` is 1 from the following cycle.
- R3: For a nonzero divisor, `done` goes high exactly W+1 clock edges after the accepting edge. That is W iteration edges plus one correction edge. `busy` stays high until then.
- R4: For every pair of W-bit unsigned operands with a nonzero divisor, `quotient` equals floor(dividend / divisor), `remainder` equals dividend mod divisor, and `div_by_zero` is 0.
- R5: When the partial remainder is negative after the last iteration, the divisor is added back once. For example, 8 divided by 3 returns quotient 2 and remainder 2.
- R6: A zero divisor gives `done` one edge after the accepting edge, with `div_by_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R7: `done` is high for exactly one cycle per division, and `busy` and `done` are never high together.
- R8: A `start` pulse while `busy` is high is ignored. Neither the timing nor the values of the running division change.
- R9: `quotient`, `remainder` and `div_by_zero` keep their values in every cycle in which `done` is low.
- R10: A `start` sampled in the same cycle that `done` is high is accepted as a new division. No idle gap is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; operands are sampled with it |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: the result ports were just updated |
| quotient | output | W | Quotient, or all ones on a zero divisor |
| remainder | output | W | Remainder, or the dividend on a zero divisor |
| div_by_zero | output | 1 | The last result came from a zero divisor |

## Verification
Two events can fall in the same cycle: the `done` pulse of one division and the `start` of the next. The bench provokes this by raising `start` with fresh operands in the very cycle it sees `done` high. It judges the case by three things: `busy` must rise on the next cycle, the second result must arrive after the full latency, and the first result must stay on the ports until then. The second collision is a `start` issued while `busy` is high. That case is judged by the first division finishing on time with its own operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_ZERO = 2'd3
  } div_state_e;
endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dvs_zero,
  output logic accept,
  output logic step_en,
  output logic fix_en,
  output logic zero_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e   state_q;
  logic [CW-1:0] iter_q;

  assign busy    = (state_q != ST_IDLE);
  assign accept  = start && (state_q == ST_IDLE);
  assign step_en = (state_q == ST_RUN);
  assign fix_en  = (state_q == ST_FIX);
  assign zero_en = (state_q == ST_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= fix_en || zero_en;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          iter_q  <= '0;
          state_q <= dvs_zero ? ST_ZERO : ST_RUN;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        ST_ZERO: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_en,
  input  logic         fix_en,
  input  logic         zero_en,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] m_held,
  output logic         a_neg,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         dz_o
);
  logic [W:0]   a_q;
  logic [W-1:0] q_q;
  logic [W-1:0] m_q;

  // One iteration: shift {A,Q} left, then add or subtract M by A's old sign.
  function automatic logic [W:0] next_a(input logic [W:0] a,
                                        input logic [W-1:0] q,
                                        input logic [W-1:0] m);
    logic [W:0] sh;
    sh = {a[W-1:0], q[W-1]};
    return a[W] ? (sh + {1'b0, m}) : (sh - {1'b0, m});
  endfunction

  function automatic logic [W-1:0] next_q(input logic [W-1:0] q,
                                          input logic [W:0] a_new);
    return {q[W-2:0], ~a_new[W]};
  endfunction

  // Final correction: add M once when the partial remainder is negative.
  function automatic logic [W:0] fix_a(input logic [W:0] a,
                                       input logic [W-1:0] m);
    return a[W] ? (a + {1'b0, m}) : a;
  endfunction

  logic [W:0] a_step;
  logic [W:0] a_fixed;

  assign a_step  = next_a(a_q, q_q, m_q);
  assign a_fixed = fix_a(a_q, m_q);
  assign m_held  = m_q;
  assign a_neg   = a_q[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      q_q   <= '0;
      m_q   <= '0;
      quo_o <= '0;
      rem_o <= '0;
      dz_o  <= 1'b0;
    end else begin
      if (load) begin
        a_q <= '0;
        q_q <= dvd_in;
        m_q <= dvs_in;
      end else if (step_en) begin
        a_q <= a_step;
        q_q <= next_q(q_q, a_step);
      end
      if (fix_en) begin
        quo_o <= q_q;
        rem_o <= a_fixed[W-1:0];
        dz_o  <= 1'b0;
      end else if (zero_en) begin
        quo_o <= '1;
        rem_o <= q_q;
        dz_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  logic         accept;
  logic         step_en;
  logic         fix_en;
  logic         zero_en;
  logic         a_neg;
  logic [W-1:0] m_held;

  nrdiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dvs_zero (divisor == '0),
    .accept   (accept),
    .step_en  (step_en),
    .fix_en   (fix_en),
    .zero_en  (zero_en),
    .busy     (busy),
    .done     (done)
  );

  nrdiv_datapath #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step_en (step_en),
    .fix_en  (fix_en),
    .zero_en (zero_en),
    .dvd_in  (dividend),
    .dvs_in  (divisor),
    .m_held  (m_held),
    .a_neg   (a_neg),
    .quo_o   (quotient),
    .rem_o   (remainder),
    .dz_o    (div_by_zero)
  );
endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         busy,
  input logic         done,
  input logic         step_en,
  input logic         fix_en,
  input logic         a_neg,
  input logic [W-1:0] m_held,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);
  localparam int CW = $clog2(W + 3);
  logic [CW-1:0] since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      since_start <= '0;
    else if (accept) since_start <= '0;
    else if (busy)   since_start <= since_start + 1'b1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> since_start == CW'(W + 1));
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> remainder < m_held);
  a_r5_fix_clears_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && a_neg) |=> (remainder < m_held));
  a_r6_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (since_start == CW'(1) && quotient == '1));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |-> !accept);
  a_r9_hold_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

bind seq_nr_divider nrdiv_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .busy        (busy),
  .done        (done),
  .step_en     (step_en),
  .fix_en      (fix_en),
  .a_neg       (a_neg),
  .m_held      (m_held),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero)
);

// File: tb/seq_nr_divider_tb.sv
module seq_nr_divider_tb;
  localparam int W = 5;
  localparam int MAXV = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int lat = 0;

  always #5 clk = ~clk;

  seq_nr_divider #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present operands and a start pulse on the next edge (called away from edges).
  task automatic issue(input int a, input int b);
    dividend = W'(a);
    divisor  = W'(b);
    start    = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  // Count edges after acceptance until done is seen.
  task automatic wait_done();
    lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!done && lat < 4 * W + 10);
  endtask

  task automatic judge(input int a, input int b);
    if (b == 0) begin
      chk("R6 latency", lat, 1);
      chk("R6 quotient", int'(quotient), MAXV - 1);
      chk("R6 remainder", int'(remainder), a);
      chk("R6 flag", int'(div_by_zero), 1);
    end else begin
      chk("R3 latency", lat, W + 1);
      chk("R4 quotient", int'(quotient), a / b);
      chk("R4 remainder", int'(remainder), a % b);
      chk("R4 flag", int'(div_by_zero), 0);
    end
    chk("R7 busy low at done", int'(busy), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int q0, r0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 flag", int'(div_by_zero), 0);
    chk("R1 quotient", int'(quotient), 0);
    chk("R1 remainder", int'(remainder), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 worked case with a negative final partial remainder
    issue(8, 3);
    chk("R2 busy after start", int'(busy), 1);
    wait_done();
    chk("R5 latency", lat, W + 1);
    chk("R5 quotient", int'(quotient), 2);
    chk("R5 remainder", int'(remainder), 2);
    @(posedge clk); #1;
    chk("R7 done one cycle", int'(done), 0);

    // R4 / R6 exhaustive sweep
    for (int a = 0; a < MAXV; a++) begin
      for (int b = 0; b < MAXV; b++) begin
        issue(a, b);
        wait_done();
        judge(a, b);
        @(posedge clk); #1;
      end
    end

    // R8 start while busy is ignored
    issue(29, 4);
    @(posedge clk); #1;
    @(posedge clk); #1;
    dividend = W'(7); divisor = W'(0); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 3;
    while (!done && lat < 4 * W + 10) begin
      @(posedge clk); #1;
      lat++;
    end
    chk("R8 latency", lat, W + 1);
    chk("R8 quotient", int'(quotient), 7);
    chk("R8 remainder", int'(remainder), 1);
    chk("R8 flag", int'(div_by_zero), 0);

    // R10 start in the done cycle; R9 hold while the next one runs
    q0 = int'(quotient); r0 = int'(remainder);
    issue(30, 7);
    chk("R10 busy", int'(busy), 1);
    chk("R9 hold quotient", int'(quotient), q0);
    chk("R9 hold remainder", int'(remainder), r0);
    wait_done();
    chk("R10 latency", lat, W + 1);
    chk("R10 quotient", int'(quotient), 4);
    chk("R10 remainder", int'(remainder), 2);

    // R9 flag clears on next nonzero result, values hold when idle
    issue(13, 0);
    wait_done();
    judge(13, 0);
    repeat (4) @(posedge clk);
    #1;
    chk("R9 idle hold flag", int'(div_by_zero), 1);
    chk("R9 idle hold remainder", int'(remainder), 13);
    issue(13, 5);
    wait_done();
    chk("R9 flag cleared", int'(div_by_zero), 0);
    chk("R9 quotient", int'(quotient), 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule